// File: doc/BRIEF.md
# Six-Phase Dead-Time PWM Generator

This block drives a three-phase bridge. A 16-bit triangle carrier runs between 0001H and a crest of m+1, where m is the programmed cycle value. Each of the three phases compares the carrier against its own duty value to form a basic phase wave. Each basic wave then feeds its own dead-time engine. The engine produces a true gate and a reverse gate, and it never lets both gates of a phase conduct at once.

Software loads the cycle value, the three duties and one shared dead-time value through a plain write port. A write takes effect on the next clock edge. Reload is not double-buffered, so the cycle value is meant to be changed while the block is disabled. A one-clock turn pulse marks every crest and every trough of the carrier, and it can be used to start a converter. While `en` is low, the carrier parks at zero and all six gates stay off.

Top module: `six_phase_pwm`

## Requirements
- R1: While `rst_n` is low, all six gates and `carrier_turn` are 0. One clock after `en` is sampled low, all six gates are 0 and the carrier is back at zero.
- R2: Once enabled, the carrier steps by one per clock. It rises 1, 2, …, m+1, holds m+1 for a second clock, then falls to 1 and holds 1 for a second clock. The full period is 2×(m+1) clocks, and successive turn pulses are m+1 clocks apart. m is valid from 0002H to FFFEH.
- R3: `carrier_turn` is high for exactly one clock: the first clock at the crest, and the first clock at the trough. It is never high on two clocks in a row.
- R4: The basic wave of a phase is high while 1 ≤ carrier ≤ duty. With duty 0000H the true gate never turns on. With duty m+1 the reverse gate never turns on once running.
- R5: When the basic wave of a phase toggles and the dead-time value D is nonzero, both gates of that phase are 0 from the next clock on. The gate that matches the new level turns on after D clocks of both-off.
- R6: With D = 0, each phase switches without any gap, so exactly one of its two gates is high on every running clock.
- R7: If the basic wave holds a level for fewer than D clocks, the gate for that level never turns on.
- R8: Each phase counts its own dead time. A suppressed or blanked phase does not delay the switching of the other two.
- R9: Write port addresses are: 0 for the cycle value m, 1 for duty U, 2 for duty V, 3 for duty W, and 4 for dead time (bits 9:0 of `wr_data`). Addresses 5 to 7 change nothing.
- R10: The true gate and the reverse gate of one phase are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the carrier and turns all gates off |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R9) |
| wr_data | input | 16 | Write data |
| u_hi | output | 1 | Phase U true gate |
| u_lo | output | 1 | Phase U reverse gate |
| v_hi | output | 1 | Phase V true gate |
| v_lo | output | 1 | Phase V reverse gate |
| w_hi | output | 1 | Phase W true gate |
| w_lo | output | 1 | Phase W reverse gate |
| carrier_turn | output | 1 | One-clock pulse at each crest and trough |

## Verification
The three phases start at duties 3, 7 and m+1 with a two-clock dead time. This mix separates ordinary pulses from the pinned-high extreme, and the spacing of the turn pulses exposes any error in the turnaround holds. Setting a duty to zero and then the dead time to zero tells the constant-low case apart from gapless complementary switching. A duty of 2 against a dead time of 5 gives a pulse shorter than the dead time, so the suppressed U phase can be checked against the still-switching V phase. Writes to unused addresses, followed by a cycle change from 10 to 20, show whether the address decode is exact.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

  // write port register selects
  localparam logic [2:0] SEL_CYCLE  = 3'd0;
  localparam logic [2:0] SEL_DUTY_U = 3'd1;
  localparam logic [2:0] SEL_DUTY_V = 3'd2;
  localparam logic [2:0] SEL_DUTY_W = 3'd3;
  localparam logic [2:0] SEL_DEAD   = 3'd4;

  typedef enum logic {SLOPE_UP = 1'b1, SLOPE_DOWN = 1'b0} slope_e;

  // basic phase level: on while the carrier sits in 1..duty
  function automatic logic phase_on(input int unsigned carrier, input int unsigned duty);
    return (carrier != 0) && (carrier <= duty);
  endfunction

  // crest of the triangle for a programmed cycle value
  function automatic int unsigned crest_of(input int unsigned cycle);
    return cycle + 1;
  endfunction

endpackage

// File: rtl/pwm6_regs.sv
module pwm6_regs #(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 10,
  parameter int PH     = 3,
  parameter int RST_CY = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [2:0]                wr_addr,
  input  logic [CNT_W-1:0]          wr_data,
  output logic [CNT_W-1:0]          cycle_q,
  output logic [PH-1:0][CNT_W-1:0]  duty_q,
  output logic [DT_W-1:0]           dead_q
);
  import pwm6_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q <= CNT_W'(RST_CY);
      duty_q  <= '0;
      dead_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == SEL_CYCLE) cycle_q <= wr_data;
      if (wr_addr == SEL_DEAD)  dead_q  <= wr_data[DT_W-1:0];
      for (int p = 0; p < PH; p++) begin
        if (wr_addr == SEL_DUTY_U + 3'(p)) duty_q[p] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/pwm6_carrier.sv
module pwm6_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cycle,
  output logic [CNT_W-1:0] cnt,
  output logic             turn
);
  import pwm6_pkg::*;

  slope_e           slope_q;
  logic [CNT_W-1:0] crest;
  logic             at_crest;
  logic             at_trough;

  assign crest     = CNT_W'(crest_of(32'(cycle)));
  assign at_crest  = (cnt == crest);
  assign at_trough = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      slope_q <= SLOPE_UP;
    end else if (!en) begin
      cnt     <= '0;
      slope_q <= SLOPE_UP;
    end else if (slope_q == SLOPE_UP) begin
      if (at_crest) slope_q <= SLOPE_DOWN;
      else          cnt     <= cnt + CNT_W'(1);
    end else begin
      if (at_trough) slope_q <= SLOPE_UP;
      else           cnt     <= cnt - CNT_W'(1);
    end
  end

  assign turn = ((slope_q == SLOPE_UP) && at_crest) ||
                ((slope_q == SLOPE_DOWN) && at_trough);

  // R2
  rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slope_q == SLOPE_UP && !at_crest) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R2
  fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slope_q == SLOPE_DOWN && !at_trough) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R3
  turn_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn |=> !turn);
  // R1
  park_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

endmodule

// File: rtl/pwm6_deadband.sv
module pwm6_deadband #(
  parameter int DT_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            basic,
  input  logic [DT_W-1:0] dead,
  output logic            hi_q,
  output logic            lo_q
);
  logic            lvl_q;
  logic            wait_q;
  logic [DT_W-1:0] gap_q;
  logic            edge_w;
  logic            zero_dead;
  logic            gap_done;

  assign edge_w    = (basic != lvl_q);
  assign zero_dead = (dead == '0);
  assign gap_done  = (gap_q >= dead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      wait_q <= 1'b1;
      gap_q  <= DT_W'(1);
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else if (!en) begin
      lvl_q  <= 1'b0;
      wait_q <= 1'b1;
      gap_q  <= DT_W'(1);
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else if (edge_w) begin
      lvl_q <= basic;
      gap_q <= DT_W'(1);
      if (zero_dead) begin
        hi_q   <= basic;
        lo_q   <= !basic;
        wait_q <= 1'b0;
      end else begin
        hi_q   <= 1'b0;
        lo_q   <= 1'b0;
        wait_q <= 1'b1;
      end
    end else if (wait_q) begin
      if (gap_done) begin
        hi_q   <= lvl_q;
        lo_q   <= !lvl_q;
        wait_q <= 1'b0;
      end else begin
        gap_q <= gap_q + DT_W'(1);
      end
    end
  end

  // R10
  pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_q && lo_q));
  // R5
  edge_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_w && !zero_dead) |=> (!hi_q && !lo_q));
  // R6
  edge_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_w && zero_dead) |=> (hi_q != lo_q));

endmodule

// File: rtl/six_phase_pwm.sv
module six_phase_pwm #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             u_hi,
  output logic             u_lo,
  output logic             v_hi,
  output logic             v_lo,
  output logic             w_hi,
  output logic             w_lo,
  output logic             carrier_turn
);
  import pwm6_pkg::*;

  localparam int PH = 3;

  logic [CNT_W-1:0]         cycle_q;
  logic [PH-1:0][CNT_W-1:0] duty_q;
  logic [DT_W-1:0]          dead_q;
  logic [CNT_W-1:0]         carrier;
  logic [PH-1:0]            basic;
  logic [PH-1:0]            gate_hi;
  logic [PH-1:0]            gate_lo;

  pwm6_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .PH(PH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cycle_q(cycle_q), .duty_q(duty_q), .dead_q(dead_q)
  );

  pwm6_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst_n(rst_n), .en(en), .cycle(cycle_q),
    .cnt(carrier), .turn(carrier_turn)
  );

  for (genvar g = 0; g < PH; g++) begin : g_phase
    assign basic[g] = phase_on(32'(carrier), 32'(duty_q[g]));
    pwm6_deadband #(.DT_W(DT_W)) u_db (
      .clk(clk), .rst_n(rst_n), .en(en), .basic(basic[g]), .dead(dead_q),
      .hi_q(gate_hi[g]), .lo_q(gate_lo[g])
    );
  end

  assign u_hi = gate_hi[0];
  assign u_lo = gate_lo[0];
  assign v_hi = gate_hi[1];
  assign v_lo = gate_lo[1];
  assign w_hi = gate_hi[2];
  assign w_lo = gate_lo[2];

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_hi == '0 && gate_lo == '0));

endmodule

// File: tb/six_phase_pwm_test.sv
module six_phase_pwm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic u_hi, u_lo, v_hi, v_lo, w_hi, w_lo, carrier_turn;

  always #10 clk = ~clk;

  six_phase_pwm uut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .u_hi(u_hi), .u_lo(u_lo), .v_hi(v_hi), .v_lo(v_lo), .w_hi(w_hi), .w_lo(w_lo),
    .carrier_turn(carrier_turn)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  int m_pos = 0;
  bit m_rising = 1;
  int m_cycle = 2;
  int m_duty[3] = '{0, 0, 0};
  int m_dead = 0;
  bit m_level[3];
  int m_held[3];
  bit m_live[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_rising = 1; m_cycle = 2; m_dead = 0;
      for (int p = 0; p < 3; p++) begin
        m_duty[p] = 0; m_level[p] = 0; m_held[p] = 0; m_live[p] = 0;
      end
    end else begin : step
      bit want[3];
      for (int p = 0; p < 3; p++) want[p] = (m_pos >= 1) && (m_pos <= m_duty[p]);
      if (!en) begin
        m_pos = 0; m_rising = 1;
        for (int p = 0; p < 3; p++) begin m_level[p] = 0; m_held[p] = 0; m_live[p] = 0; end
      end else begin
        if (m_rising) begin
          if (m_pos == m_cycle + 1) m_rising = 0; else m_pos++;
        end else begin
          if (m_pos == 1) m_rising = 1; else m_pos--;
        end
        for (int p = 0; p < 3; p++) begin
          if (want[p] != m_level[p]) begin
            m_level[p] = want[p]; m_held[p] = 0; m_live[p] = 0;
          end else if (m_held[p] < 100000) begin
            m_held[p]++;
          end
          if (m_held[p] >= m_dead) m_live[p] = 1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_cycle = int'(wr_data);
          3'd1: m_duty[0] = int'(wr_data);
          3'd2: m_duty[1] = int'(wr_data);
          3'd3: m_duty[2] = int'(wr_data);
          3'd4: m_dead = int'(wr_data[9:0]);
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk({u_hi, u_lo, v_hi, v_lo, w_hi, w_lo, carrier_turn} == 7'b0, "R1 outputs in reset",
          int'({u_hi, u_lo, v_hi, v_lo, w_hi, w_lo, carrier_turn}), 0);
    end else begin : cmp
      bit hi[3];
      bit lo[3];
      bit exp_turn;
      hi = '{u_hi, v_hi, w_hi};
      lo = '{u_lo, v_lo, w_lo};
      exp_turn = (m_rising && m_pos == m_cycle + 1) || (!m_rising && m_pos == 1);
      chk(carrier_turn == exp_turn, "R3 turn pulse", int'(carrier_turn), int'(exp_turn));
      for (int p = 0; p < 3; p++) begin
        chk(hi[p] == (m_live[p] && m_level[p]), "R5/R8 true gate", int'(hi[p]),
            int'(m_live[p] && m_level[p]));
        chk(lo[p] == (m_live[p] && !m_level[p]), "R5/R8 reverse gate", int'(lo[p]),
            int'(m_live[p] && !m_level[p]));
        chk(!(hi[p] && lo[p]), "R10 pair overlap", int'(hi[p] && lo[p]), 0);
      end
    end
  end

  // observation window
  int n_hi[3];
  int n_lo[3];
  int n_gapped;
  int spacing;
  int spacing_bad;
  int n_turns;

  task automatic observe(input int n);
    int last = -1;
    for (int p = 0; p < 3; p++) begin n_hi[p] = 0; n_lo[p] = 0; end
    n_gapped = 0; spacing = -1; spacing_bad = 0; n_turns = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      n_hi[0] += int'(u_hi); n_lo[0] += int'(u_lo);
      n_hi[1] += int'(v_hi); n_lo[1] += int'(v_lo);
      n_hi[2] += int'(w_hi); n_lo[2] += int'(w_lo);
      if (!(u_hi ^ u_lo) || !(v_hi ^ v_lo) || !(w_hi ^ w_lo)) n_gapped++;
      if (carrier_turn) begin
        if (last >= 0) begin
          if (spacing < 0) spacing = i - last;
          else if (i - last != spacing) spacing_bad++;
        end
        last = i;
        n_turns++;
      end
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(carrier_turn == 1'b0 && u_hi == 1'b0 && w_lo == 1'b0, "R1 idle after reset", int'(carrier_turn), 0);

    // R9: program registers through the port
    wr(3'd0, 16'd10);
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd7);
    wr(3'd3, 16'd11);
    wr(3'd4, 16'd2);
    en = 1'b1;
    repeat (4) @(negedge clk);
    observe(100);
    chk(spacing == 11 && spacing_bad == 0, "R2 half period m=10", spacing, 11);
    chk(n_turns >= 8, "R3 turn count", n_turns, 9);
    chk(n_lo[2] == 0, "R4 duty m+1 keeps reverse gate off", n_lo[2], 0);
    chk(n_hi[2] > 0, "R4 duty m+1 true gate on", n_hi[2], 1);
    chk(n_hi[0] > 0 && n_lo[0] > 0, "R5 U switches both ways", n_hi[0], 1);

    // R4: duty zero
    wr(3'd1, 16'd0);
    repeat (6) @(negedge clk);
    observe(60);
    chk(n_hi[0] == 0, "R4 duty 0 keeps true gate off", n_hi[0], 0);
    chk(n_lo[0] > 0, "R4 duty 0 reverse gate on", n_lo[0], 1);

    // R6: no dead time
    wr(3'd4, 16'd0);
    wr(3'd1, 16'd5);
    repeat (3) @(negedge clk);
    observe(60);
    chk(n_gapped == 0, "R6 complementary without gap", n_gapped, 0);
    chk(n_hi[0] > 0 && n_lo[0] > 0, "R6 U toggles", n_lo[0], 1);

    // R7 / R8: pulse shorter than dead time
    wr(3'd4, 16'd5);
    wr(3'd1, 16'd2);
    repeat (25) @(negedge clk);
    observe(66);
    chk(n_hi[0] == 0, "R7 short pulse suppressed", n_hi[0], 0);
    chk(n_lo[0] > 0, "R7 long level still drives", n_lo[0], 1);
    chk(n_hi[1] > 0 && n_lo[1] > 0, "R8 V unaffected by U", n_hi[1], 1);

    // R9: unused addresses do nothing
    wr(3'd5, 16'd3);
    wr(3'd6, 16'd2);
    wr(3'd7, 16'd4);
    observe(66);
    chk(spacing == 11 && spacing_bad == 0, "R9 unused address ignored", spacing, 11);
    chk(n_hi[0] == 0, "R9 dead time kept", n_hi[0], 0);

    // R1: disable
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk({u_hi, u_lo, v_hi, v_lo, w_hi, w_lo} == 6'b0, "R1 gates off when disabled",
        int'({u_hi, u_lo, v_hi, v_lo, w_hi, w_lo}), 0);
    observe(10);
    chk(n_turns == 0, "R1 carrier parked", n_turns, 0);

    // R2 / R9: new cycle value
    wr(3'd0, 16'd20);
    en = 1'b1;
    repeat (4) @(negedge clk);
    observe(130);
    chk(spacing == 21 && spacing_bad == 0, "R2 half period m=20", spacing, 21);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

endmodule